// File: doc/BRIEF.md
# Log-Domain Phong Lighting Pipeline

This block computes one scalar Phong lighting intensity per accepted operand set. The operands are the ambient, diffuse and specular material coefficients, the matching light intensities, the clamped diffuse dot product N·L, the clamped specular dot product R·V and a shininess exponent. The datapath contains no floating-point multiplier and no power unit. Each operand is converted to a base-2 logarithm with a piecewise-linear approximation. Inside each term, the products become additions of logarithms. The specular power becomes a single signed multiply of the shininess by log2(R·V). Each of the three terms is converted back to the linear domain, and the three results are summed with saturation.

The ambient, diffuse and specular terms run side by side in separate datapaths. A new operand set can be presented on every clock, and each result appears a fixed four cycles later. A shading engine streams vertices or pixels into the block and reads the intensities out in the order they went in. Any term that has a zero operand skips the logarithm path and contributes nothing to the result.

Top module: `phong_log_lighting`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and on the first cycle after it is released, `out_valid` is 0 and `out_intensity` is 0.
- R2: An operand set sampled with `in_valid` high at a rising edge produces `out_valid` high exactly 4 rising edges later, counting the sampling edge as the first. Sets sampled on consecutive edges give results on consecutive cycles, in order. Cycles with `in_valid` low give no `out_valid`.
- R3: Every operand is unsigned Q0.16 (value x/65536). For a nonzero operand x, let p be the position of its leading one (0..15). Let f be the 15 bits below the leading one, left-aligned, with value f/32768. Then L = (p-16)·32768 + y, where y is chosen by the top three bits of f:
  - codes 0–1: y = f + (f>>2)
  - codes 2–3: y = f + 2048
  - codes 4–5: y = f - (f>>3) + 4608
  - code 6: y = (f>>1) + (f>>2) + (f>>4) + 6656
  - code 7: y = (f>>1) + (f>>2) + 8192
  - All shifts truncate.
- R4: A term log S (signed, 15 fraction bits) is converted back to linear form as follows. Let i = floor(S/32768) and g = S mod 32768. A correction m is chosen by the top two bits of g:
  - code 0: m = (g>>1) + (g>>2)
  - code 1: m = g - (g>>3) - 1024
  - code 2: m = g + (g>>4) - 4096
  - code 3: m = g + (g>>2) - 8192
  - Let M = 32768 + m. If i >= 0 the term is 65535. If -i-1 >= 16 the term is 0. Otherwise the term is M >> (-i-1).
- R5: The ambient term is the antilog of L(ka) + L(Ia).
- R6: The diffuse term is the antilog of L(kd) + L(Id) + L(N·L).
- R7: `in_shine` is unsigned Q4.4. The specular term is the antilog of L(ks) + L(Is) + P. P is the signed product L(R·V)·n, arithmetically shifted right by 4, which discards the low product bits.
- R8: A term with any zero operand contributes 0 to the result, and so does the specular term when R·V is 0. With all three coefficients zero, the result is 0.
- R9: `out_intensity` is the sum of the three terms, saturated to 65535. It is never less than any single term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present this cycle |
| in_ka | input | 16 | Ambient coefficient, Q0.16 |
| in_ia | input | 16 | Ambient light intensity, Q0.16 |
| in_kd | input | 16 | Diffuse coefficient, Q0.16 |
| in_id | input | 16 | Diffuse light intensity, Q0.16 |
| in_ndotl | input | 16 | Clamped N·L, Q0.16 |
| in_ks | input | 16 | Specular coefficient, Q0.16 |
| in_is | input | 16 | Specular light intensity, Q0.16 |
| in_rdotv | input | 16 | Clamped R·V, Q0.16 |
| in_shine | input | 8 | Shininess exponent, unsigned Q4.4 |
| out_valid | output | 1 | Result present this cycle |
| out_intensity | output | 16 | Saturated lighting intensity, Q0.16 |

## Verification
Two cases are hard to reach from the ports. One is the antilog's far-negative range, where the right shift reaches the full width and the term must vanish. The other is saturation of the final sum. Neither appears unless several operands sit at the extremes of their range together. Directed sets use operands of one LSB with a large shininess to drive the specular log far below -16. Sets with every operand at full scale push the ambient and diffuse terms near one each, so their sum overflows. Operands of exactly one half and all-ones land on the first and last approximation segments, and a pseudo-random stream with bubbles covers the segments in between.

// File: rtl/lpl_pkg.sv
package lpl_pkg;

    parameter int DW     = 16;           // operand and result width, unsigned Q0.DW
    parameter int NW     = 8;            // shininess width
    parameter int NF     = 4;            // shininess fraction bits
    parameter int LW     = 32;           // signed log word width
    parameter int STAGES = 4;            // pipeline depth

    localparam int LF    = DW - 1;       // log fraction bits
    localparam int PW    = $clog2(DW);   // leading-one position width
    localparam int OPS   = 8;            // operands converted to log
    localparam int TERMS = 3;            // ambient, diffuse, specular

    localparam int OP_KA = 0;
    localparam int OP_IA = 1;
    localparam int OP_KD = 2;
    localparam int OP_ID = 3;
    localparam int OP_NL = 4;
    localparam int OP_KS = 5;
    localparam int OP_IS = 6;
    localparam int OP_RV = 7;

    localparam int T_AMB = 0;
    localparam int T_DIF = 1;
    localparam int T_SPC = 2;

    typedef logic [DW-1:0]        data_t;
    typedef logic [NW-1:0]        shin_t;
    typedef logic [LF-1:0]        frac_t;
    typedef logic signed [LW-1:0] log_t;

    typedef struct packed {
        logic zero;
        log_t val;
    } log_res_t;

    typedef struct packed {
        log_t             amb;
        log_t             dif;
        log_t             spc_base;
        log_t             spc_pow;
        logic [TERMS-1:0] zero;
    } s2_t;

    typedef enum logic [2:0] {LSEG_A, LSEG_B, LSEG_C, LSEG_D, LSEG_E} lseg_e;
    typedef enum logic [1:0] {ASEG_A, ASEG_B, ASEG_C, ASEG_D} aseg_e;

    function automatic lseg_e log_seg(input frac_t f);
        unique case (f[LF-1 -: 3])
            3'd0, 3'd1: return LSEG_A;
            3'd2, 3'd3: return LSEG_B;
            3'd4, 3'd5: return LSEG_C;
            3'd6:       return LSEG_D;
            default:    return LSEG_E;
        endcase
    endfunction

    // log2(1+f) by five shift-and-add chords
    function automatic frac_t log_pwl(input frac_t f);
        logic [LF:0] w;
        logic [LF:0] acc;
        w = {1'b0, f};
        unique case (log_seg(f))
            LSEG_A:  acc = w + (w >> 2);
            LSEG_B:  acc = w + ((LF+1)'(1) << (LF-4));
            LSEG_C:  acc = w - (w >> 3) + ((LF+1)'(1) << (LF-3)) + ((LF+1)'(1) << (LF-6));
            LSEG_D:  acc = (w >> 1) + (w >> 2) + (w >> 4) + ((LF+1)'(13) << (LF-6));
            default: acc = (w >> 1) + (w >> 2) + ((LF+1)'(1) << (LF-2));
        endcase
        return frac_t'(acc);
    endfunction

    // 2^g - 1 by four shift-and-add chords
    function automatic frac_t exp_pwl(input frac_t g);
        logic [LF:0] w;
        logic [LF:0] acc;
        w = {1'b0, g};
        unique case (aseg_e'(g[LF-1 -: 2]))
            ASEG_A:  acc = (w >> 1) + (w >> 2);
            ASEG_B:  acc = w - (w >> 3) - ((LF+1)'(1) << (LF-5));
            ASEG_C:  acc = w + (w >> 4) - ((LF+1)'(1) << (LF-3));
            default: acc = w + (w >> 2) - ((LF+1)'(1) << (LF-2));
        endcase
        return frac_t'(acc);
    endfunction

endpackage

// File: rtl/lpl_log_conv.sv
module lpl_log_conv
    import lpl_pkg::*;
(
    input  data_t    x,
    output log_res_t r
);
    logic [PW-1:0] pos;
    frac_t         f;
    frac_t         y;
    log_t          ip;

    always_comb begin
        pos = '0;
        for (int i = 0; i < DW; i++) begin
            if (x[i]) pos = PW'(i);
        end
        f      = frac_t'(x << (DW - 1 - int'(pos)));
        y      = log_pwl(f);
        ip     = log_t'(pos) - log_t'(DW);
        r.zero = (x == '0);
        r.val  = r.zero ? '0 : (ip <<< LF) + log_t'(y);
    end
endmodule

// File: rtl/lpl_spec_power.sv
module lpl_spec_power
    import lpl_pkg::*;
(
    input  log_t  lg,
    input  shin_t n,
    output log_t  p
);
    log_t                     nx;
    logic signed [LW+NF-1:0]  wide;

    always_comb begin
        nx   = log_t'(n);
        wide = lg * nx;
        p    = log_t'(wide >>> NF);
    end
endmodule

// File: rtl/lpl_antilog_conv.sv
module lpl_antilog_conv
    import lpl_pkg::*;
(
    input  log_t  lg,
    input  logic  zero,
    output data_t y
);
    localparam log_t DW_L = log_t'(DW);

    log_t  ip;
    log_t  sh;
    frac_t g;
    frac_t m;
    data_t mant;

    always_comb begin
        ip   = lg >>> LF;
        g    = lg[LF-1:0];
        m    = exp_pwl(g);
        mant = {1'b1, m};
        sh   = -ip - 1;
        if (zero)
            y = '0;
        else if (!ip[LW-1])
            y = '1;
        else if (sh >= DW_L)
            y = '0;
        else
            y = mant >> sh;
    end
endmodule

// File: rtl/phong_log_lighting.sv
module phong_log_lighting
    import lpl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  data_t in_ka,
    input  data_t in_ia,
    input  data_t in_kd,
    input  data_t in_id,
    input  data_t in_ndotl,
    input  data_t in_ks,
    input  data_t in_is,
    input  data_t in_rdotv,
    input  shin_t in_shine,
    output logic  out_valid,
    output data_t out_intensity
);
    localparam logic [DW+1:0] SAT_MAX = (DW+2)'({DW{1'b1}});

    data_t            ops     [OPS];
    log_res_t         lg_c    [OPS];
    log_res_t         s1_lg   [OPS];
    shin_t            s1_n;
    log_t             pow_c;
    s2_t              s2_d;
    s2_t              s2_q;
    log_t             term_lg [TERMS];
    logic             term_zero [TERMS];
    data_t            term_c  [TERMS];
    data_t            s3_term [TERMS];
    logic [DW+1:0]    total;
    logic [STAGES-1:0] vld;

    assign ops[OP_KA] = in_ka;
    assign ops[OP_IA] = in_ia;
    assign ops[OP_KD] = in_kd;
    assign ops[OP_ID] = in_id;
    assign ops[OP_NL] = in_ndotl;
    assign ops[OP_KS] = in_ks;
    assign ops[OP_IS] = in_is;
    assign ops[OP_RV] = in_rdotv;

    // stage 1: all operands to the log domain
    generate
        for (genvar gi = 0; gi < OPS; gi++) begin : g_log
            lpl_log_conv u_log (.x(ops[gi]), .r(lg_c[gi]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < OPS; i++) s1_lg[i] <= '0;
            s1_n <= '0;
        end else begin
            for (int i = 0; i < OPS; i++) s1_lg[i] <= lg_c[i];
            s1_n <= in_shine;
        end
    end

    // stage 2: products as log sums, power as one multiply
    lpl_spec_power u_pow (.lg(s1_lg[OP_RV].val), .n(s1_n), .p(pow_c));

    always_comb begin
        s2_d.amb      = s1_lg[OP_KA].val + s1_lg[OP_IA].val;
        s2_d.dif      = s1_lg[OP_KD].val + s1_lg[OP_ID].val + s1_lg[OP_NL].val;
        s2_d.spc_base = s1_lg[OP_KS].val + s1_lg[OP_IS].val;
        s2_d.spc_pow  = pow_c;
        s2_d.zero[T_AMB] = s1_lg[OP_KA].zero | s1_lg[OP_IA].zero;
        s2_d.zero[T_DIF] = s1_lg[OP_KD].zero | s1_lg[OP_ID].zero | s1_lg[OP_NL].zero;
        s2_d.zero[T_SPC] = s1_lg[OP_KS].zero | s1_lg[OP_IS].zero | s1_lg[OP_RV].zero;
    end

    always_ff @(posedge clk) begin
        if (rst) s2_q <= '0;
        else     s2_q <= s2_d;
    end

    // stage 3: three parallel antilog converters
    always_comb begin
        term_lg[T_AMB] = s2_q.amb;
        term_lg[T_DIF] = s2_q.dif;
        term_lg[T_SPC] = s2_q.spc_base + s2_q.spc_pow;
        for (int t = 0; t < TERMS; t++) term_zero[t] = s2_q.zero[t];
    end

    generate
        for (genvar ti = 0; ti < TERMS; ti++) begin : g_alog
            lpl_antilog_conv u_alog (.lg(term_lg[ti]), .zero(term_zero[ti]), .y(term_c[ti]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) for (int t = 0; t < TERMS; t++) s3_term[t] <= '0;
        else     for (int t = 0; t < TERMS; t++) s3_term[t] <= term_c[t];
    end

    // stage 4: saturating sum
    always_comb begin
        total = '0;
        for (int t = 0; t < TERMS; t++) total = total + (DW+2)'(s3_term[t]);
    end

    always_ff @(posedge clk) begin
        if (rst) out_intensity <= '0;
        else     out_intensity <= (total > SAT_MAX) ? '1 : total[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= {vld[STAGES-2:0], in_valid};
    end

    assign out_valid = vld[STAGES-1];

endmodule

// File: rtl/lpl_checker.sv
module lpl_checker
    import lpl_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  in_valid,
    input data_t in_ka,
    input data_t in_kd,
    input data_t in_ks,
    input logic  out_valid,
    input data_t out_intensity,
    input data_t term_amb,
    input data_t term_dif,
    input data_t term_spc
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_intensity == '0));

    assert_issue_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##4 out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 4));

    assert_zero_coeffs_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_ka == '0 && in_kd == '0 && in_ks == '0, 4)) |-> out_intensity == '0);

    assert_sum_dominates_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_intensity >= $past(term_amb) &&
                       out_intensity >= $past(term_dif) &&
                       out_intensity >= $past(term_spc)));
endmodule

bind phong_log_lighting lpl_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_ka(in_ka), .in_kd(in_kd), .in_ks(in_ks),
    .out_valid(out_valid), .out_intensity(out_intensity),
    .term_amb(s3_term[0]), .term_dif(s3_term[1]), .term_spc(s3_term[2])
);

// File: tb/phong_log_lighting_test.sv
module phong_log_lighting_test;
    import lpl_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  in_valid = 1'b0;
    data_t in_ka = '0, in_ia = '0, in_kd = '0, in_id = '0, in_ndotl = '0;
    data_t in_ks = '0, in_is = '0, in_rdotv = '0;
    shin_t in_shine = '0;
    logic  out_valid;
    data_t out_intensity;

    phong_log_lighting uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_ka(in_ka), .in_ia(in_ia), .in_kd(in_kd), .in_id(in_id), .in_ndotl(in_ndotl),
        .in_ks(in_ks), .in_is(in_is), .in_rdotv(in_rdotv), .in_shine(in_shine),
        .out_valid(out_valid), .out_intensity(out_intensity)
    );

    always #5 clk = ~clk;

    typedef struct {
        int ka; int ia; int kd; int id; int nl; int ks; int il; int rv; int n;
    } vec_t;

    typedef struct {
        int     val;
        longint due;
        string  tag;
    } item_t;

    item_t  sb[$];
    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     done = 0;
    int unsigned seed = 32'h1234_5677;

    always @(posedge clk) cyc <= cyc + 1;

    // reference log per R3
    function automatic longint mlog(input int x);
        int p; int f; int y;
        p = 0;
        for (int i = 0; i < 16; i++) if (x[i]) p = i;
        f = (x << (15 - p)) & 32'h7FFF;
        case (f >> 12)
            0, 1:    y = f + (f >> 2);
            2, 3:    y = f + 2048;
            4, 5:    y = f - (f >> 3) + 4608;
            6:       y = (f >> 1) + (f >> 2) + (f >> 4) + 6656;
            default: y = (f >> 1) + (f >> 2) + 8192;
        endcase
        return longint'(p - 16) * 32768 + longint'(y);
    endfunction

    // reference antilog per R4
    function automatic int malog(input longint s);
        longint i; longint g; longint m; longint sh;
        i = s >>> 15;
        g = s & 32767;
        case (g >> 13)
            0:       m = (g >> 1) + (g >> 2);
            1:       m = g - (g >> 3) - 1024;
            2:       m = g + (g >> 4) - 4096;
            default: m = g + (g >> 2) - 8192;
        endcase
        if (i >= 0) return 65535;
        sh = -i - 1;
        if (sh >= 16) return 0;
        return int'((32768 + m) >> sh);
    endfunction

    function automatic int model(input vec_t v);
        int a; int d; int s; int t;
        a = (v.ka == 0 || v.ia == 0) ? 0 : malog(mlog(v.ka) + mlog(v.ia));
        d = (v.kd == 0 || v.id == 0 || v.nl == 0) ? 0 :
            malog(mlog(v.kd) + mlog(v.id) + mlog(v.nl));
        s = (v.ks == 0 || v.il == 0 || v.rv == 0) ? 0 :
            malog(mlog(v.ks) + mlog(v.il) + ((mlog(v.rv) * longint'(v.n)) >>> 4));
        t = a + d + s;
        return (t > 65535) ? 65535 : t;
    endfunction

    function automatic vec_t mkvec(input int ka, ia, kd, id, nl, ks, il, rv, n);
        vec_t v;
        v.ka = ka; v.ia = ia; v.kd = kd; v.id = id; v.nl = nl;
        v.ks = ks; v.il = il; v.rv = rv; v.n = n;
        return v;
    endfunction

    function automatic int unsigned nxt(input int unsigned s);
        int unsigned r;
        r = s ^ (s << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: present one set and queue its expected result
    task automatic drive(input vec_t v, input int exp, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_ka = data_t'(v.ka); in_ia = data_t'(v.ia); in_kd = data_t'(v.kd);
        in_id = data_t'(v.id); in_ndotl = data_t'(v.nl); in_ks = data_t'(v.ks);
        in_is = data_t'(v.il); in_rdotv = data_t'(v.rv); in_shine = shin_t'(v.n);
        it.val = exp; it.due = cyc + 4; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 valid without input", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(cyc == it.due, "R2 latency cycle", cyc, it.due);
                    check(int'(out_intensity) == it.val, it.tag, out_intensity, it.val);
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                check(1'b0, "R2 missing result", 0, 1);
                void'(sb.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected drained");
        finish_run();
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        check(out_intensity == '0, "R1 intensity after reset", out_intensity, 0);

        // R5 ambient only: 0.5*0.5 -> 16384
        drive(mkvec(32'h8000, 32'h8000, 0, 0, 0, 0, 0, 0, 0), 16384, "R5 ambient half*half");
        // R3/R4 top log segment and top antilog segment
        drive(mkvec(32'hFFFF, 32'hFFFF, 0, 0, 0, 0, 0, 0, 0), 65531, "R3 R4 full-scale ambient");
        // R7 specular: (0.5)^2 with full-scale ks, Is
        drive(mkvec(0, 0, 0, 0, 0, 32'hFFFF, 32'hFFFF, 32'h8000, 32'h20), 16382, "R7 specular squared");
        // R7 fractional exponent, truncated product
        v = mkvec(0, 0, 0, 0, 0, 32'hC000, 32'hE000, 32'h9000, 32'h01);
        drive(v, model(v), "R7 fractional exponent");
        v = mkvec(0, 0, 0, 0, 0, 32'h7000, 32'hFFFF, 32'hF123, 32'hFF);
        drive(v, model(v), "R7 large exponent");
        // R4 far-negative log vanishes
        drive(mkvec(0, 0, 0, 0, 0, 32'hFFFF, 32'hFFFF, 32'h0001, 32'hFF), 0, "R4 deep antilog shift");
        // R6 diffuse across segments
        v = mkvec(0, 0, 32'hA000, 32'hD800, 32'hB400, 0, 0, 0, 0);
        drive(v, model(v), "R6 diffuse mid segments");
        v = mkvec(0, 0, 32'h0003, 32'h7FFF, 32'h4321, 0, 0, 0, 0);
        drive(v, model(v), "R6 diffuse small coefficient");
        // R8 zero operands bypass
        v = mkvec(32'h9000, 32'hA000, 0, 32'hFFFF, 32'hFFFF, 32'h8000, 32'h8000, 0, 32'h10);
        drive(v, model(v), "R8 zero kd and zero rdotv");
        drive(mkvec(0, 32'hFFFF, 0, 32'hFFFF, 32'hFFFF, 0, 32'hFFFF, 32'hFFFF, 32'h10), 0,
              "R8 all coefficients zero");
        // R9 saturation
        drive(mkvec(32'hFFFF, 32'hFFFF, 32'hFFFF, 32'hFFFF, 32'hFFFF, 0, 0, 0, 0), 65535,
              "R9 saturated sum");
        v = mkvec(32'h3000, 32'h6000, 32'h5000, 32'h7000, 32'hE000, 32'h4000, 32'hC000, 32'hF800, 32'h50);
        drive(v, model(v), "R9 three-term sum");
        idle();
        idle();

        // R2 streaming with bubbles, R9 mixed operands
        for (int k = 0; k < 80; k++) begin
            int f[9];
            for (int j = 0; j < 9; j++) begin
                seed = nxt(seed);
                f[j] = int'(seed & 32'hFFFF);
                if (j < 8 && seed[28:26] == 3'd0) f[j] = 0;
            end
            f[8] = f[8] & 32'hFF;
            v = mkvec(f[0], f[1], f[2], f[3], f[4], f[5], f[6], f[7], f[8]);
            drive(v, model(v), "R2 R9 streamed set");
            if (seed[31:30] == 2'd0) idle();
        end
        idle();

        while (sb.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        finish_run();
    end
endmodule